// File: doc/BRIEF.md
# Paged Descriptor Ring Address Generator

This block converts free-running ring indices into physical descriptor addresses for three rings that a host shares with a storage adapter: a request ring the device consumes, a completion ring the device fills, and a message ring the device fills with event notices. No ring has to be contiguous. Each one occupies a small table of page frames, and every frame holds a fixed number of descriptors. Before a ring can be set up, the host loads its page frame numbers one at a time. A commit then gives the page count. From that count the block derives the ring's index mask and clears the ring's pointer.

The descriptor address comes from the masked index. The high part of the masked index picks a page frame from the table. The low part, scaled by the descriptor size, gives the byte offset inside that page. The block also tells the host how far each ring has progressed. It does this through a write-back port that emits one ring-state field per cycle. On setup it emits zeroed producer and consumer fields and the log2 entry count. It emits the consumed pointer when a request batch is flushed, the fill pointer when a completion batch is flushed, and the fill pointer after every accepted message.

Top module: `desc_ring_addrgen`

## Requirements
- R1: A commit with page count N gives a ring of N·E entries, where E = 2^(PAGE_SHIFT − descriptor log2): 32 for requests, 128 for completions and 64 for messages at the defaults. The published log2 is k, the position one above the highest set bit of N·E−1, and the index mask is 2^k−1. Examples: N=4 requests gives k=7, N=3 completions gives k=9.
- R2: The descriptor address is (frame[(ptr & mask) / E] << PAGE_SHIFT) + ((ptr & mask) mod E) · descriptor bytes. A request address is always aligned to the descriptor size. The index wraps to page 0 when the pointer passes the mask.
- R3: `req_avail` is high only when the request ring is configured and `req_prod_idx` differs from the consumed pointer. A `req_pop` with `req_avail` high advances the consumed pointer by one. A pop without it is ignored.
- R4: `req_flush` on a configured request ring emits field 1 (request consumer) carrying the consumed pointer. The value includes any pop made in the same cycle.
- R5: Each `cmp_push` on a configured completion ring advances the fill pointer, with no check for room, and the address wraps at the mask. `cmp_flush` emits field 3 (completion producer) carrying the fill pointer.
- R6: A message push is accepted only while (fill − `msg_cons_idx`) mod 2^32 < mask+1. An accepted push advances the fill pointer and emits field 6 (message producer) carrying the new pointer. A refused push changes nothing and emits nothing.
- R7: Write-back field codes are 0/1/2 for request producer/consumer/log2, 3/4/5 for the completion ring and 6/7/8 for the message ring. A commit on ring r (0 request, 1 completion, 2 message) emits fields 3r, 3r+1 and 3r+2 with data 0, 0 and k. When several fields are pending, the lowest code is sent first, one per cycle.
- R8: A commit is ignored when the page count is 0 or larger than MAX_PAGES. A message-ring commit is also ignored unless both data rings are configured.
- R9: `cleanup` zeroes every pointer, mask, log2 and page frame, marks all rings unconfigured and drops pending write-backs. A cleanup takes priority over any command in the same cycle.
- R10: After reset no write-back is emitted, no ring is configured and every address is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ring | input | 2 | Ring selected by a page write or a commit (0 request, 1 completion, 2 message) |
| cfg_page_we | input | 1 | Write one page frame number into the selected ring's table |
| cfg_page_sel | input | PG_W | Table slot to write |
| cfg_page_ppn | input | PPN_W | Page frame number |
| cfg_commit | input | 1 | Set up the selected ring with page count `cfg_npages` |
| cfg_npages | input | CNT_W | Page count for a commit |
| cleanup | input | 1 | Zero all ring state |
| req_prod_idx | input | 32 | Host producer index of the request ring |
| req_pop | input | 1 | Fetch the request descriptor at `req_addr` |
| req_flush | input | 1 | Publish the consumed pointer |
| req_avail | output | 1 | A request descriptor is pending |
| req_addr | output | ADDR_W | Address of the next request descriptor |
| cmp_push | input | 1 | Claim the completion slot at `cmp_addr` |
| cmp_flush | input | 1 | Publish the completion fill pointer |
| cmp_ready | output | 1 | Completion ring configured |
| cmp_addr | output | ADDR_W | Address of the next completion slot |
| msg_cons_idx | input | 32 | Host consumer index of the message ring |
| msg_push | input | 1 | Claim the message slot at `msg_addr` |
| msg_room | output | 1 | Message ring configured and not full |
| msg_addr | output | ADDR_W | Address of the next message slot |
| ws_valid | output | 1 | A ring-state field write is presented |
| ws_field | output | 4 | Field code of the write |
| ws_data | output | 32 | Value written |

## Verification
The bench drives the request ring across a page boundary and across the wrap at the mask. A design that divided the raw pointer instead of the masked one would run past the last page. The bench pushes the completion ring past its capacity, where a design that checked for room would stall. It fills the message ring exactly to capacity and then sets the host consumer index ahead of the fill pointer. A design whose room check did not wrap modulo 2^32 would accept a push there. The remaining cases are these. A page count of 3 must round the mask up to 2^9−1. Commits with a page count of zero, a page count above the table depth, or a message commit before the data rings exist must all stay silent. A cleanup in the same cycle as a flush must win. After a cleanup the page frames must read back as zero, which a design that only cleared the masks would miss.

// File: rtl/ring_ag_pkg.sv
package ring_ag_pkg;

  localparam int NUM_RINGS       = 3;
  localparam int FIELDS_PER_RING = 3;
  localparam int NUM_FIELDS      = NUM_RINGS * FIELDS_PER_RING;

  localparam logic [1:0] RING_REQ = 2'd0;
  localparam logic [1:0] RING_CMP = 2'd1;
  localparam logic [1:0] RING_MSG = 2'd2;

  // Ring-state field codes; the lowest pending code is written first.
  typedef enum logic [3:0] {
    WB_REQ_PROD = 4'd0,
    WB_REQ_CONS = 4'd1,
    WB_REQ_LOG2 = 4'd2,
    WB_CMP_PROD = 4'd3,
    WB_CMP_CONS = 4'd4,
    WB_CMP_LOG2 = 4'd5,
    WB_MSG_PROD = 4'd6,
    WB_MSG_CONS = 4'd7,
    WB_MSG_LOG2 = 4'd8
  } wb_field_e;

endpackage

// File: rtl/ring_size_log2.sv
// Derives the published log2 and the index mask from a page count.
module ring_size_log2 #(
  parameter int CNT_W    = 4,
  parameter int EPP_LOG2 = 5
) (
  input  logic [CNT_W-1:0] npages,
  output logic [5:0]       log2_o,
  output logic [31:0]      mask_o
);

  localparam int CAP_W = CNT_W + EPP_LOG2;

  logic [CAP_W-1:0] cap_m1;

  always_comb begin
    cap_m1 = {npages, {EPP_LOG2{1'b0}}} - CAP_W'(1);
    log2_o = '0;
    for (int i = 0; i < CAP_W; i++) begin
      if (cap_m1[i]) log2_o = 6'(i + 1);
    end
    mask_o = '0;
    for (int i = 0; i < 32; i++) begin
      if (i < int'(log2_o)) mask_o[i] = 1'b1;
    end
  end

endmodule

// File: rtl/ring_page_table.sv
// Per-ring table of page frame numbers, one register per slot.
module ring_page_table #(
  parameter int MAX_PAGES = 8,
  parameter int PPN_W     = 40,
  parameter int PG_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             we,
  input  logic [PG_W-1:0]  wsel,
  input  logic [PPN_W-1:0] wppn,
  input  logic [PG_W-1:0]  rsel,
  output logic [PPN_W-1:0] rppn
);

  logic [PPN_W-1:0] slot_q [MAX_PAGES];

  for (genvar g = 0; g < MAX_PAGES; g++) begin : g_slot
    logic             slot_en;
    logic [PPN_W-1:0] slot_d;

    always_comb begin
      slot_en = clear || (we && (wsel == PG_W'(g)));
      slot_d  = clear ? '0 : wppn;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q[g] <= '0;
      else if (slot_en) slot_q[g] <= slot_d;
    end
  end

  always_comb begin
    rppn = '0;
    for (int i = 0; i < MAX_PAGES; i++) begin
      if (rsel == PG_W'(i)) rppn = slot_q[i];
    end
  end

endmodule

// File: rtl/ring_addr_map.sv
// Splits a masked ring index into page select and in-page byte offset.
module ring_addr_map #(
  parameter int IDX_W      = 8,
  parameter int EPP_LOG2   = 5,
  parameter int DESC_LOG2  = 7,
  parameter int PG_W       = 3,
  parameter int PPN_W      = 40,
  parameter int PAGE_SHIFT = 12
) (
  input  logic [IDX_W-1:0]            ptr_lo,
  input  logic [IDX_W-1:0]            mask_lo,
  input  logic [PPN_W-1:0]            page_ppn,
  output logic [PG_W-1:0]             page_sel,
  output logic [PPN_W+PAGE_SHIFT-1:0] addr
);

  localparam int ADDR_W = PPN_W + PAGE_SHIFT;

  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] offset;

  always_comb begin
    idx      = ptr_lo & mask_lo;
    page_sel = PG_W'(idx[IDX_W-1:EPP_LOG2]);
    base     = {page_ppn, {PAGE_SHIFT{1'b0}}};
    offset   = ADDR_W'(idx[EPP_LOG2-1:0]) << DESC_LOG2;
    addr     = base + offset;
  end

endmodule

// File: rtl/ring_lane.sv
// One ring: page table, geometry registers, free-running pointer, address.
module ring_lane #(
  parameter int MAX_PAGES  = 8,
  parameter int PPN_W      = 40,
  parameter int PAGE_SHIFT = 12,
  parameter int DESC_LOG2  = 7,
  parameter int PG_W       = 3,
  parameter int CNT_W      = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear,
  input  logic                        tbl_we,
  input  logic [PG_W-1:0]             tbl_sel,
  input  logic [PPN_W-1:0]            tbl_ppn,
  input  logic                        commit,
  input  logic [CNT_W-1:0]            commit_npages,
  input  logic                        advance,
  output logic                        valid_o,
  output logic [31:0]                 ptr_o,
  output logic [31:0]                 mask_o,
  output logic [5:0]                  log2_o,
  output logic [PPN_W+PAGE_SHIFT-1:0] addr_o
);

  localparam int EPP_LOG2 = PAGE_SHIFT - DESC_LOG2;
  localparam int IDX_W    = PG_W + EPP_LOG2;

  logic        valid_q, valid_d;
  logic [31:0] ptr_q, ptr_d;
  logic [31:0] mask_q, mask_d;
  logic [5:0]  log2_q, log2_d;
  logic        state_en;
  logic [5:0]  calc_log2;
  logic [31:0] calc_mask;
  logic [PG_W-1:0]  page_sel;
  logic [PPN_W-1:0] page_ppn;

  ring_size_log2 #(
    .CNT_W    (CNT_W),
    .EPP_LOG2 (EPP_LOG2)
  ) u_size (
    .npages (commit_npages),
    .log2_o (calc_log2),
    .mask_o (calc_mask)
  );

  ring_page_table #(
    .MAX_PAGES (MAX_PAGES),
    .PPN_W     (PPN_W),
    .PG_W      (PG_W)
  ) u_tbl (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear),
    .we    (tbl_we),
    .wsel  (tbl_sel),
    .wppn  (tbl_ppn),
    .rsel  (page_sel),
    .rppn  (page_ppn)
  );

  ring_addr_map #(
    .IDX_W      (IDX_W),
    .EPP_LOG2   (EPP_LOG2),
    .DESC_LOG2  (DESC_LOG2),
    .PG_W       (PG_W),
    .PPN_W      (PPN_W),
    .PAGE_SHIFT (PAGE_SHIFT)
  ) u_map (
    .ptr_lo   (ptr_q[IDX_W-1:0]),
    .mask_lo  (mask_q[IDX_W-1:0]),
    .page_ppn (page_ppn),
    .page_sel (page_sel),
    .addr     (addr_o)
  );

  always_comb begin
    valid_d  = valid_q;
    ptr_d    = ptr_q;
    mask_d   = mask_q;
    log2_d   = log2_q;
    state_en = clear || commit || advance;
    if (clear) begin
      valid_d = 1'b0;
      ptr_d   = '0;
      mask_d  = '0;
      log2_d  = '0;
    end else if (commit) begin
      valid_d = 1'b1;
      ptr_d   = '0;
      mask_d  = calc_mask;
      log2_d  = calc_log2;
    end else if (advance) begin
      ptr_d   = ptr_q + 32'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      ptr_q   <= '0;
      mask_q  <= '0;
      log2_q  <= '0;
    end else if (state_en) begin
      valid_q <= valid_d;
      ptr_q   <= ptr_d;
      mask_q  <= mask_d;
      log2_q  <= log2_d;
    end
  end

  assign valid_o = valid_q;
  assign ptr_o   = ptr_q;
  assign mask_o  = mask_q;
  assign log2_o  = log2_q;

endmodule

// File: rtl/ring_state_wb.sv
// Pending-field scheduler for ring-state write-back, lowest code first.
module ring_state_wb
  import ring_ag_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic [NUM_FIELDS-1:0] set_i,
  input  logic [31:0]           req_ptr,
  input  logic [31:0]           cmp_ptr,
  input  logic [31:0]           msg_ptr,
  input  logic [5:0]            req_log2,
  input  logic [5:0]            cmp_log2,
  input  logic [5:0]            msg_log2,
  output logic                  ws_valid,
  output logic [3:0]            ws_field,
  output logic [31:0]           ws_data
);

  logic [NUM_FIELDS-1:0] pend_q, pend_d, grant;
  logic                  found;
  logic [3:0]            grant_idx;
  logic [31:0]           grant_data;
  logic                  pend_en;
  logic                  valid_d;

  always_comb begin
    grant     = '0;
    grant_idx = '0;
    found     = 1'b0;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (pend_q[i] && !found) begin
        grant[i]  = 1'b1;
        grant_idx = 4'(i);
        found     = 1'b1;
      end
    end

    case (grant_idx)
      WB_REQ_CONS: grant_data = req_ptr;
      WB_REQ_LOG2: grant_data = 32'(req_log2);
      WB_CMP_PROD: grant_data = cmp_ptr;
      WB_CMP_LOG2: grant_data = 32'(cmp_log2);
      WB_MSG_PROD: grant_data = msg_ptr;
      WB_MSG_LOG2: grant_data = 32'(msg_log2);
      default:     grant_data = '0;
    endcase

    pend_en = clear || found || (|set_i);
    pend_d  = clear ? '0 : ((pend_q & ~grant) | set_i);
    valid_d = found && !clear;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_valid <= 1'b0;
      ws_field <= '0;
      ws_data  <= '0;
    end else begin
      ws_valid <= valid_d;
      ws_field <= grant_idx;
      ws_data  <= grant_data;
    end
  end

endmodule

// File: rtl/desc_ring_addrgen.sv
// Top: command decode, three ring lanes and the ring-state write-back.
module desc_ring_addrgen
  import ring_ag_pkg::*;
#(
  parameter int MAX_PAGES     = 8,   // power of two keeps page select in range
  parameter int PPN_W         = 40,
  parameter int PAGE_SHIFT    = 12,
  parameter int REQ_DESC_LOG2 = 7,
  parameter int CMP_DESC_LOG2 = 5,
  parameter int MSG_DESC_LOG2 = 6,
  localparam int PG_W   = (MAX_PAGES > 1) ? $clog2(MAX_PAGES) : 1,
  localparam int CNT_W  = $clog2(MAX_PAGES + 1),
  localparam int ADDR_W = PPN_W + PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_ring,
  input  logic              cfg_page_we,
  input  logic [PG_W-1:0]   cfg_page_sel,
  input  logic [PPN_W-1:0]  cfg_page_ppn,
  input  logic              cfg_commit,
  input  logic [CNT_W-1:0]  cfg_npages,
  input  logic              cleanup,
  input  logic [31:0]       req_prod_idx,
  input  logic              req_pop,
  input  logic              req_flush,
  output logic              req_avail,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              cmp_push,
  input  logic              cmp_flush,
  output logic              cmp_ready,
  output logic [ADDR_W-1:0] cmp_addr,
  input  logic [31:0]       msg_cons_idx,
  input  logic              msg_push,
  output logic              msg_room,
  output logic [ADDR_W-1:0] msg_addr,
  output logic              ws_valid,
  output logic [3:0]        ws_field,
  output logic [31:0]       ws_data
);

  logic [NUM_RINGS-1:0]  lane_we, lane_commit, lane_adv, lane_valid;
  logic [31:0]           lane_ptr  [NUM_RINGS];
  logic [31:0]           lane_mask [NUM_RINGS];
  logic [5:0]            lane_log2 [NUM_RINGS];
  logic [ADDR_W-1:0]     lane_addr [NUM_RINGS];
  logic                  npages_ok, data_ready, commit_ok;
  logic [31:0]           msg_gap;
  logic [NUM_FIELDS-1:0] wb_set;

  for (genvar r = 0; r < NUM_RINGS; r++) begin : g_lane
    localparam int DL2 = (r == 0) ? REQ_DESC_LOG2 :
                         (r == 1) ? CMP_DESC_LOG2 : MSG_DESC_LOG2;
    ring_lane #(
      .MAX_PAGES  (MAX_PAGES),
      .PPN_W      (PPN_W),
      .PAGE_SHIFT (PAGE_SHIFT),
      .DESC_LOG2  (DL2),
      .PG_W       (PG_W),
      .CNT_W      (CNT_W)
    ) u_lane (
      .clk           (clk),
      .rst_n         (rst_n),
      .clear         (cleanup),
      .tbl_we        (lane_we[r]),
      .tbl_sel       (cfg_page_sel),
      .tbl_ppn       (cfg_page_ppn),
      .commit        (lane_commit[r]),
      .commit_npages (cfg_npages),
      .advance       (lane_adv[r]),
      .valid_o       (lane_valid[r]),
      .ptr_o         (lane_ptr[r]),
      .mask_o        (lane_mask[r]),
      .log2_o        (lane_log2[r]),
      .addr_o        (lane_addr[r])
    );
  end

  always_comb begin
    npages_ok  = (cfg_npages != '0) && (cfg_npages <= CNT_W'(MAX_PAGES));
    data_ready = lane_valid[0] && lane_valid[1];
    commit_ok  = cfg_commit && npages_ok && !cleanup &&
                 ((cfg_ring != RING_MSG) || data_ready);
    for (int r = 0; r < NUM_RINGS; r++) begin
      lane_we[r]     = cfg_page_we && !cleanup && (cfg_ring == 2'(r));
      lane_commit[r] = commit_ok && (cfg_ring == 2'(r));
    end

    req_avail = lane_valid[0] && (req_prod_idx != lane_ptr[0]);
    cmp_ready = lane_valid[1];
    msg_gap   = lane_ptr[2] - msg_cons_idx;
    msg_room  = lane_valid[2] &&
                ({1'b0, msg_gap} < ({1'b0, lane_mask[2]} + 33'd1));

    lane_adv[0] = req_pop && req_avail && !cleanup;
    lane_adv[1] = cmp_push && cmp_ready && !cleanup;
    lane_adv[2] = msg_push && msg_room && !cleanup;

    wb_set = '0;
    for (int r = 0; r < NUM_RINGS; r++) begin
      if (lane_commit[r]) wb_set[FIELDS_PER_RING*r +: FIELDS_PER_RING] = '1;
    end
    if (req_flush && lane_valid[0] && !cleanup) wb_set[int'(WB_REQ_CONS)] = 1'b1;
    if (cmp_flush && lane_valid[1] && !cleanup) wb_set[int'(WB_CMP_PROD)] = 1'b1;
    if (lane_adv[2])                            wb_set[int'(WB_MSG_PROD)] = 1'b1;

    req_addr = lane_addr[0];
    cmp_addr = lane_addr[1];
    msg_addr = lane_addr[2];
  end

  ring_state_wb u_wb (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (cleanup),
    .set_i    (wb_set),
    .req_ptr  (lane_ptr[0]),
    .cmp_ptr  (lane_ptr[1]),
    .msg_ptr  (lane_ptr[2]),
    .req_log2 (lane_log2[0]),
    .cmp_log2 (lane_log2[1]),
    .msg_log2 (lane_log2[2]),
    .ws_valid (ws_valid),
    .ws_field (ws_field),
    .ws_data  (ws_data)
  );

endmodule

// File: rtl/ring_ag_checker.sv
module ring_ag_checker #(
  parameter int ADDR_W        = 52,
  parameter int REQ_DESC_LOG2 = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_page_we,
  input logic              cfg_commit,
  input logic              cleanup,
  input logic              req_pop,
  input logic              req_avail,
  input logic [ADDR_W-1:0] req_addr,
  input logic              cmp_push,
  input logic              cmp_ready,
  input logic [ADDR_W-1:0] cmp_addr,
  input logic              msg_push,
  input logic              msg_room,
  input logic [ADDR_W-1:0] msg_addr,
  input logic              ws_valid,
  input logic [3:0]        ws_field
);

  logic quiet_cfg;
  assign quiet_cfg = !cfg_page_we && !cfg_commit && !cleanup;

  AST_REQ_POP_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_pop && !req_avail && quiet_cfg) |=> $stable(req_addr)); // R3

  AST_REQ_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    req_avail |-> (req_addr[REQ_DESC_LOG2-1:0] == '0)); // R2

  AST_CMP_ALWAYS_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_push && cmp_ready && quiet_cfg) |=> !$stable(cmp_addr)); // R5

  AST_MSG_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_push && !msg_room && quiet_cfg) |=> $stable(msg_addr)); // R6

  AST_WB_FIELD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    ws_valid |-> (ws_field <= 4'd8)); // R7

  AST_CLEANUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cleanup |=> (!ws_valid && !req_avail && !cmp_ready && !msg_room)); // R9

endmodule

bind desc_ring_addrgen ring_ag_checker #(
  .ADDR_W        (ADDR_W),
  .REQ_DESC_LOG2 (REQ_DESC_LOG2)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_page_we (cfg_page_we),
  .cfg_commit  (cfg_commit),
  .cleanup     (cleanup),
  .req_pop     (req_pop),
  .req_avail   (req_avail),
  .req_addr    (req_addr),
  .cmp_push    (cmp_push),
  .cmp_ready   (cmp_ready),
  .cmp_addr    (cmp_addr),
  .msg_push    (msg_push),
  .msg_room    (msg_room),
  .msg_addr    (msg_addr),
  .ws_valid    (ws_valid),
  .ws_field    (ws_field)
);

// File: tb/desc_ring_addrgen_tb_top.sv
`timescale 1ns/1ps
module desc_ring_addrgen_tb_top;

  localparam int AW = 52;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    cfg_ring;
  logic          cfg_page_we;
  logic [2:0]    cfg_page_sel;
  logic [39:0]   cfg_page_ppn;
  logic          cfg_commit;
  logic [3:0]    cfg_npages;
  logic          cleanup;
  logic [31:0]   req_prod_idx;
  logic          req_pop, req_flush, req_avail;
  logic [AW-1:0] req_addr;
  logic          cmp_push, cmp_flush, cmp_ready;
  logic [AW-1:0] cmp_addr;
  logic [31:0]   msg_cons_idx;
  logic          msg_push, msg_room;
  logic [AW-1:0] msg_addr;
  logic          ws_valid;
  logic [3:0]    ws_field;
  logic [31:0]   ws_data;

  always #2.5 clk = ~clk;

  desc_ring_addrgen dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_ring(cfg_ring), .cfg_page_we(cfg_page_we),
    .cfg_page_sel(cfg_page_sel), .cfg_page_ppn(cfg_page_ppn),
    .cfg_commit(cfg_commit), .cfg_npages(cfg_npages), .cleanup(cleanup),
    .req_prod_idx(req_prod_idx), .req_pop(req_pop), .req_flush(req_flush),
    .req_avail(req_avail), .req_addr(req_addr), .cmp_push(cmp_push),
    .cmp_flush(cmp_flush), .cmp_ready(cmp_ready), .cmp_addr(cmp_addr),
    .msg_cons_idx(msg_cons_idx), .msg_push(msg_push), .msg_room(msg_room),
    .msg_addr(msg_addr), .ws_valid(ws_valid), .ws_field(ws_field),
    .ws_data(ws_data)
  );

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [3:0]  f;
    logic [31:0] d;
    string       tag;
  } wb_t;
  wb_t exp_q[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic push_exp(input logic [3:0] f, input logic [31:0] d, input string tag);
    wb_t e;
    e.f = f; e.d = d; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: compares every ring-state write against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && ws_valid) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R7 unexpected write actual=%0d:0x%0h expected=none",
                 ws_field, ws_data);
      end else begin
        wb_t e;
        e = exp_q.pop_front();
        chk((ws_field == e.f) && (ws_data == e.d), e.tag, "write-back",
            {ws_field, ws_data}, {e.f, e.d});
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr_page(input logic [1:0] ring, input int sel, input longint ppn);
    cfg_ring = ring; cfg_page_sel = 3'(sel); cfg_page_ppn = 40'(ppn);
    cfg_page_we = 1'b1;
    step();
    cfg_page_we = 1'b0;
  endtask

  task automatic commit(input logic [1:0] ring, input int np);
    cfg_ring = ring; cfg_npages = 4'(np); cfg_commit = 1'b1;
    step();
    cfg_commit = 1'b0;
  endtask

  function automatic logic [AW-1:0] req_exp(input int i);
    return (AW'(64'h100 + ((i & 127) >> 5)) << 12) + AW'((i & 31) * 128);
  endfunction
  function automatic logic [AW-1:0] cmp_exp(input int i);
    return (AW'(64'h200) << 12) + AW'((i & 127) * 32);
  endfunction
  function automatic logic [AW-1:0] msg_exp(input int i);
    return (AW'(64'h300 + ((i & 127) >> 6)) << 12) + AW'((i & 63) * 64);
  endfunction

  initial begin
    #500000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [AW-1:0] held;
    rst_n = 1'b0; cfg_ring = '0; cfg_page_we = 1'b0; cfg_page_sel = '0;
    cfg_page_ppn = '0; cfg_commit = 1'b0; cfg_npages = '0; cleanup = 1'b0;
    req_prod_idx = '0; req_pop = 1'b0; req_flush = 1'b0; cmp_push = 1'b0;
    cmp_flush = 1'b0; msg_cons_idx = '0; msg_push = 1'b0;
    repeat (3) step();

    // R10 reset state
    chk(!ws_valid, "R10", "ws_valid", ws_valid, 0);
    chk(!req_avail && !cmp_ready && !msg_room, "R10", "ready flags",
        {req_avail, cmp_ready, msg_room}, 0);
    chk(req_addr == 0 && cmp_addr == 0 && msg_addr == 0, "R10", "addresses",
        req_addr | cmp_addr | msg_addr, 0);
    rst_n = 1'b1;
    step();

    // R8 ignored commits: message before data rings, zero pages, too many pages
    commit(2'd2, 1);
    commit(2'd0, 0);
    commit(2'd0, 9);
    req_prod_idx = 32'd1;
    repeat (4) step();
    chk(!msg_room, "R8", "msg_room after early message commit", msg_room, 0);
    chk(!req_avail, "R8", "req_avail after bad page counts", req_avail, 0);

    // R7 / R1 request ring setup: 4 pages, 32 entries each, log2 7
    for (int p = 0; p < 4; p++) wr_page(2'd0, p, 64'h100 + p);
    req_prod_idx = 32'd0;
    push_exp(4'd0, 32'd0, "R7");
    push_exp(4'd1, 32'd0, "R7");
    push_exp(4'd2, 32'd7, "R1");
    commit(2'd0, 4);
    repeat (5) step();
    chk(!req_avail, "R3", "req_avail with equal indices", req_avail, 0);

    // R3 / R2 three fetches
    req_prod_idx = 32'd3;
    #1;
    chk(req_avail, "R3", "req_avail with producer ahead", req_avail, 1);
    for (int i = 0; i < 3; i++) begin
      req_pop = 1'b1;
      #1;
      chk(req_addr == req_exp(i), "R2", "request address", req_addr, req_exp(i));
      step();
    end
    req_pop = 1'b0;
    #1;
    chk(!req_avail, "R3", "req_avail after catching up", req_avail, 0);
    req_pop = 1'b1;
    step();
    req_pop = 1'b0;
    #1;
    chk(req_addr == req_exp(3), "R3", "pop while empty ignored", req_addr, req_exp(3));

    // R4 flush publishes consumed pointer
    push_exp(4'd1, 32'd3, "R4");
    req_flush = 1'b1;
    step();
    req_flush = 1'b0;
    repeat (3) step();

    // R2 page crossing and wrap at the mask
    req_prod_idx = 32'd130;
    for (int i = 3; i < 130; i++) begin
      req_pop = 1'b1;
      #1;
      chk(req_addr == req_exp(i), "R2", "request address across pages",
          req_addr, req_exp(i));
      step();
    end
    req_pop = 1'b0;
    #1;
    chk(!req_avail, "R3", "req_avail after 130 fetches", req_avail, 0);
    push_exp(4'd1, 32'd130, "R4");
    req_flush = 1'b1;
    step();
    req_flush = 1'b0;
    repeat (3) step();

    // R5 completion ring: one page of 128 entries, pushed past capacity
    wr_page(2'd1, 0, 64'h200);
    push_exp(4'd3, 32'd0, "R7");
    push_exp(4'd4, 32'd0, "R7");
    push_exp(4'd5, 32'd7, "R1");
    commit(2'd1, 1);
    repeat (5) step();
    for (int i = 0; i < 130; i++) begin
      cmp_push = 1'b1;
      #1;
      chk(cmp_ready && cmp_addr == cmp_exp(i), "R5", "completion address",
          cmp_addr, cmp_exp(i));
      step();
    end
    cmp_push = 1'b0;
    push_exp(4'd3, 32'd130, "R5");
    cmp_flush = 1'b1;
    step();
    cmp_flush = 1'b0;
    repeat (3) step();

    // R1 non-power-of-two page count rounds the mask up
    push_exp(4'd3, 32'd0, "R7");
    push_exp(4'd4, 32'd0, "R7");
    push_exp(4'd5, 32'd9, "R1");
    commit(2'd1, 3);
    repeat (5) step();
    chk(cmp_addr == cmp_exp(0), "R1", "completion pointer cleared by setup",
        cmp_addr, cmp_exp(0));

    // R6 message ring: two pages of 64 entries
    wr_page(2'd2, 0, 64'h300);
    wr_page(2'd2, 1, 64'h301);
    msg_cons_idx = 32'd0;
    push_exp(4'd6, 32'd0, "R7");
    push_exp(4'd7, 32'd0, "R7");
    push_exp(4'd8, 32'd7, "R1");
    commit(2'd2, 2);
    repeat (5) step();
    for (int i = 0; i < 128; i++) begin
      msg_push = 1'b1;
      #1;
      chk(msg_room && msg_addr == msg_exp(i), "R6", "message address with room",
          {msg_room, msg_addr}, {1'b1, msg_exp(i)});
      push_exp(4'd6, 32'(i + 1), "R6");
      step();
      msg_push = 1'b0;
      step();
    end
    repeat (2) step();
    chk(!msg_room, "R6", "msg_room at capacity", msg_room, 0);
    held = msg_addr;
    msg_push = 1'b1;
    step();
    msg_push = 1'b0;
    repeat (3) step();
    chk(msg_addr == held, "R6", "refused push keeps address", msg_addr, held);
    msg_cons_idx = 32'd1;
    #1;
    chk(msg_room, "R6", "msg_room after host consumes one", msg_room, 1);
    msg_cons_idx = 32'd200;
    #1;
    chk(!msg_room, "R6", "msg_room with consumer ahead wraps mod 2^32", msg_room, 0);

    // R9 cleanup wins over a same-cycle flush
    req_prod_idx = 32'd5;
    #1;
    chk(req_avail, "R3", "req_avail before cleanup", req_avail, 1);
    req_flush = 1'b1;
    cleanup = 1'b1;
    step();
    req_flush = 1'b0;
    cleanup = 1'b0;
    repeat (3) step();
    chk(!req_avail && !cmp_ready && !msg_room, "R9", "flags after cleanup",
        {req_avail, cmp_ready, msg_room}, 0);
    chk(req_addr == 0 && cmp_addr == 0 && msg_addr == 0, "R9",
        "addresses after cleanup", req_addr | cmp_addr | msg_addr, 0);

    // R9 page table cleared: recommit without writing frames
    push_exp(4'd0, 32'd0, "R7");
    push_exp(4'd1, 32'd0, "R7");
    push_exp(4'd2, 32'd5, "R1");
    commit(2'd0, 1);
    repeat (5) step();
    req_pop = 1'b1;
    step();
    req_pop = 1'b0;
    #1;
    chk(req_avail && req_addr == AW'(128), "R9", "frame zero after cleanup",
        req_addr, 128);

    repeat (4) step();
    chk(exp_q.size() == 0, "R7", "all expected writes seen", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule